// File: doc/BRIEF.md
# Core Voltage Ramp Sequencer

This block produces the digital target code that a core regulator follows. When the requested operating point changes, the code does not jump. It walks toward the new value in steps of programmable height, with a programmable wait between steps. The current drawn from a weak external supply therefore rises gently instead of spiking. Software writes a performance-level code. The block also watches two level inputs: one marks that the chip is in standby, the other marks that a background task is running during standby. Any change of the resulting target starts a new walk.

The block drives only the voltage code. Clock generators, dividers and flash wait states are left untouched. Software must order those against the ready flag. Once a climb to the high level has finished, the block sets a ready flag. That flag can raise an interrupt. All pins are plain control and status signals. No data stream crosses the block edge, so it has no valid/ready handshake and no back-pressure.

Top module: `core_vramp_seq`

## Requirements
- R1: After reset, `vcode` equals `LOW_CODE`, and `pl_rdy` and `irq` are 0.
- R2: A write of level code 0 selects the low level (`LOW_CODE`), and a write of code 2 selects the high level (`HIGH_CODE`). A write of code 1 or 3 is ignored: the code, the target and the ready flag are unchanged.
- R3: Every change of `vcode` moves it toward the target by exactly 2^`step_hgt` code units, where one unit is 5 mV. The only exception is the final step.
- R4: Consecutive steps of a walk are exactly `TICKS_PER_US` << `step_per` clock cycles apart.
- R5: The final step is clamped so that `vcode` lands exactly on the target and never passes it.
- R6: While `stby` is 1 and `task_act` is 0, the target is the low level. When either input releases it, the target returns to the selected level.
- R7: While `stby` is 1, a `task_act` of 1 restores the selected level as the target.
- R8: `pl_rdy` becomes 1 one cycle after `vcode` lands on `HIGH_CODE` while the target is high and a move or a high write is pending. An accepted level write clears it.
- R9: A pulse on `rdy_clr` clears `pl_rdy`. A set event in the same cycle wins over the clear.
- R10: `irq` is 1 exactly when `pl_rdy` is 1 and `rdy_ie` is 1.
- R11: A new target that arrives during a walk redirects the walk from the current code, without a return to either end point.
- R12: While `vcode` equals the target, it holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also times the step period |
| rst_n | input | 1 | Active-low asynchronous reset |
| pl_we | input | 1 | One-cycle strobe that writes `pl_code` |
| pl_code | input | 2 | Level code: 0 low, 2 high, others ignored |
| stby | input | 1 | 1 while the chip is in standby |
| task_act | input | 1 | 1 while a background task runs |
| step_hgt | input | HGT_W | Step height exponent (2^n units of 5 mV) |
| step_per | input | PER_W | Step period exponent (TICKS_PER_US << n cycles) |
| rdy_clr | input | 1 | Write-one pulse that clears the ready flag |
| rdy_ie | input | 1 | Ready interrupt enable |
| vcode | output | CODE_W | Voltage code sent to the regulator |
| pl_rdy | output | 1 | High level reached |
| irq | output | 1 | Ready interrupt |

## Verification
The step-size assertion compares each change against the step height of the previous cycle. It therefore assumes that `step_hgt` and `step_per` are only changed while the code rests on its target. The random stimulus writes new settings only after a walk has settled. The no-back-to-back-step check relies on `TICKS_PER_US` being at least 2. The bench keeps the level inputs and write strobes apart by whole cycles, and it starts each new random action only after the previous walk has landed and the ready flag has settled.

// File: rtl/vramp_pkg.sv
package vramp_pkg;
  typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} lvl_e;
  localparam logic [1:0] PL_CODE_LOW  = 2'd0;
  localparam logic [1:0] PL_CODE_HIGH = 2'd2;
endpackage

// File: rtl/vramp_req.sv
module vramp_req
  import vramp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pl_we,
  input  logic [1:0] pl_code,
  input  logic       stby,
  input  logic       task_act,
  output logic       accept,
  output logic       accept_hi,
  output lvl_e       tgt_lvl
);
  lvl_e sel_q;

  // only the two defined level codes are accepted
  always_comb begin
    accept    = pl_we && (pl_code == PL_CODE_LOW || pl_code == PL_CODE_HIGH);
    accept_hi = pl_we && (pl_code == PL_CODE_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= LVL_LOW;
    else if (accept) sel_q <= accept_hi ? LVL_HIGH : LVL_LOW;
  end

  // standby without a running task parks the core at the low level
  always_comb tgt_lvl = (stby && !task_act) ? LVL_LOW : sel_q;
endmodule

// File: rtl/vramp_timer.sv
module vramp_timer #(
  parameter int TICKS_PER_US = 4,
  parameter int PER_W        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] per_sel,
  output logic             fire
);
  localparam int MAX_P = TICKS_PER_US << ((1 << PER_W) - 1);
  localparam int CW    = $clog2(MAX_P + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    last = CW'((TICKS_PER_US << per_sel) - 1);
    fire = run && (cnt == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (cnt == last) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vramp_stepper.sv
module vramp_stepper #(
  parameter int CODE_W = 8,
  parameter int HGT_W  = 2,
  parameter logic [CODE_W-1:0] LOW_CODE = 8'd180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] tgt_code,
  input  logic [HGT_W-1:0]  step_hgt,
  input  logic              fire,
  output logic [CODE_W-1:0] vcode,
  output logic              at_tgt
);
  logic [CODE_W-1:0] step_amt;
  logic [CODE_W-1:0] gap;
  logic [CODE_W-1:0] nxt;
  logic              going_up;

  always_comb begin
    step_amt = CODE_W'(1) << step_hgt;
    going_up = tgt_code > vcode;
    gap      = going_up ? (tgt_code - vcode) : (vcode - tgt_code);
    at_tgt   = (gap == '0);
    if (gap <= step_amt)  nxt = tgt_code;      // clamp the last step
    else if (going_up)    nxt = vcode + step_amt;
    else                  nxt = vcode - step_amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vcode <= LOW_CODE;
    else if (fire) vcode <= nxt;
  end
endmodule

// File: rtl/vramp_flag.sv
module vramp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic accept_hi,
  input  logic tgt_hi,
  input  logic at_high,
  input  logic rdy_clr,
  input  logic rdy_ie,
  output logic pl_rdy,
  output logic irq
);
  logic armed;
  logic set_ev;

  always_comb set_ev = tgt_hi && armed && at_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     armed <= 1'b0;
    else if (!tgt_hi)               armed <= 1'b0;
    else if (armed && at_high)      armed <= 1'b0;
    else if (accept_hi || !at_high) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pl_rdy <= 1'b0;
    else if (accept)  pl_rdy <= 1'b0;
    else if (set_ev)  pl_rdy <= 1'b1;
    else if (rdy_clr) pl_rdy <= 1'b0;
  end

  always_comb irq = pl_rdy && rdy_ie;
endmodule

// File: rtl/core_vramp_seq.sv
module core_vramp_seq
  import vramp_pkg::*;
#(
  parameter int CODE_W       = 8,
  parameter int HGT_W        = 2,
  parameter int PER_W        = 2,
  parameter int TICKS_PER_US = 4,
  parameter logic [CODE_W-1:0] LOW_CODE  = 8'd180,
  parameter logic [CODE_W-1:0] HIGH_CODE = 8'd240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_we,
  input  logic [1:0]        pl_code,
  input  logic              stby,
  input  logic              task_act,
  input  logic [HGT_W-1:0]  step_hgt,
  input  logic [PER_W-1:0]  step_per,
  input  logic              rdy_clr,
  input  logic              rdy_ie,
  output logic [CODE_W-1:0] vcode,
  output logic              pl_rdy,
  output logic              irq
);
  logic              accept;
  logic              accept_hi;
  lvl_e              tgt_lvl;
  logic [CODE_W-1:0] tgt_code;
  logic              at_tgt;
  logic              fire;
  logic              at_high;

  vramp_req u_req (
    .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_code(pl_code),
    .stby(stby), .task_act(task_act),
    .accept(accept), .accept_hi(accept_hi), .tgt_lvl(tgt_lvl)
  );

  always_comb tgt_code = (tgt_lvl == LVL_HIGH) ? HIGH_CODE : LOW_CODE;

  vramp_timer #(.TICKS_PER_US(TICKS_PER_US), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(!at_tgt), .per_sel(step_per), .fire(fire)
  );

  vramp_stepper #(.CODE_W(CODE_W), .HGT_W(HGT_W), .LOW_CODE(LOW_CODE)) u_step (
    .clk(clk), .rst_n(rst_n), .tgt_code(tgt_code), .step_hgt(step_hgt),
    .fire(fire), .vcode(vcode), .at_tgt(at_tgt)
  );

  always_comb at_high = (vcode == HIGH_CODE);

  vramp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .accept(accept), .accept_hi(accept_hi),
    .tgt_hi(tgt_lvl == LVL_HIGH), .at_high(at_high),
    .rdy_clr(rdy_clr), .rdy_ie(rdy_ie), .pl_rdy(pl_rdy), .irq(irq)
  );
endmodule

// File: rtl/vramp_chk.sv
module vramp_chk #(
  parameter int CODE_W = 8,
  parameter int HGT_W  = 2,
  parameter logic [CODE_W-1:0] LOW_CODE  = 8'd180,
  parameter logic [CODE_W-1:0] HIGH_CODE = 8'd240
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] vcode,
  input logic [CODE_W-1:0] tgt_code,
  input logic [HGT_W-1:0]  step_hgt,
  input logic              pl_rdy
);
  logic [CODE_W-1:0] prev_code;
  logic [HGT_W-1:0]  prev_hgt;
  logic [CODE_W-1:0] delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_code <= LOW_CODE;
      prev_hgt  <= '0;
    end else begin
      prev_code <= vcode;
      prev_hgt  <= step_hgt;
    end
  end

  always_comb delta = (vcode >= prev_code) ? (vcode - prev_code) : (prev_code - vcode);

  // R5
  code_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode >= LOW_CODE) && (vcode <= HIGH_CODE));

  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delta <= (CODE_W'(1) << prev_hgt));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode == tgt_code) |=> $stable(vcode));

  // R4
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode != prev_code) |=> $stable(vcode));

  // R8
  rdy_at_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pl_rdy) |-> (vcode == HIGH_CODE));
endmodule

bind core_vramp_seq vramp_chk #(
  .CODE_W(CODE_W), .HGT_W(HGT_W), .LOW_CODE(LOW_CODE), .HIGH_CODE(HIGH_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vcode(vcode), .tgt_code(tgt_code),
  .step_hgt(step_hgt), .pl_rdy(pl_rdy)
);

// File: tb/tb_core_vramp_seq.sv
module tb_core_vramp_seq;
  localparam int TPU  = 4;
  localparam int LOWC = 180;
  localparam int HIC  = 240;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pl_we = 1'b0;
  logic [1:0] pl_code = 2'd0;
  logic       stby = 1'b0;
  logic       task_act = 1'b0;
  logic [1:0] step_hgt = 2'd0;
  logic [1:0] step_per = 2'd0;
  logic       rdy_clr = 1'b0;
  logic       rdy_ie = 1'b0;
  logic [7:0] vcode;
  logic       pl_rdy;
  logic       irq;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit b_sel = 0;
  bit b_rdy = 0;

  core_vramp_seq dut (
    .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_code(pl_code), .stby(stby),
    .task_act(task_act), .step_hgt(step_hgt), .step_per(step_per),
    .rdy_clr(rdy_clr), .rdy_ie(rdy_ie), .vcode(vcode), .pl_rdy(pl_rdy), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic int exp_tgt();
    if (stby && !task_act) return LOWC;
    return b_sel ? HIC : LOWC;
  endfunction

  function automatic int per_cycles();
    return TPU << step_per;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        total++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        finish_run();
      end
    end
  end

  // follow the code until it rests on its target; checks R3, R4, R5, R12
  task automatic watch(input int expv);
    int  prev, gap, serr, gerr, nst, want, stp, per;
    bit  first;
    stp = 1 << step_hgt;
    per = per_cycles();
    prev = vcode; gap = 0; serr = 0; gerr = 0; nst = 0; first = 1;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      gap++;
      if (vcode != prev) begin
        if (expv > prev) want = prev + ((expv - prev) < stp ? (expv - prev) : stp);
        else             want = prev - ((prev - expv) < stp ? (prev - expv) : stp);
        if (vcode != want) serr++;
        if (!first && gap != per) gerr++;
        first = 0; gap = 0; prev = vcode; nst++;
      end
      if (vcode == expv && c >= 2 * per + 2) break;
    end
    chk(vcode == expv, "R5 lands exactly on target", vcode, expv);
    chk(serr == 0, "R3 R12 step size and hold", serr, 0);
    if (nst > 1) chk(gerr == 0, "R4 step spacing", gerr, 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic write_pl(input logic [1:0] code);
    int oldt, newt;
    bit valid;
    oldt = exp_tgt();
    valid = (code == 2'd0 || code == 2'd2);
    @(negedge clk);
    pl_we = 1'b1; pl_code = code;
    @(negedge clk);
    pl_we = 1'b0;
    if (valid) begin
      b_sel = (code == 2'd2);
      newt = exp_tgt();
      b_rdy = (newt == HIC);
    end else begin
      newt = oldt;
    end
  endtask

  task automatic set_level(input bit s, input bit t);
    int oldt, newt;
    oldt = exp_tgt();
    @(negedge clk);
    stby = s; task_act = t;
    newt = exp_tgt();
    if (newt != oldt && newt == HIC) b_rdy = 1;
  endtask

  task automatic check_flags(input string tag);
    chk(pl_rdy == b_rdy, {"R8 ready ", tag}, pl_rdy, b_rdy);
    chk(irq == (b_rdy && rdy_ie), {"R10 irq ", tag}, irq, b_rdy && rdy_ie);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(vcode == LOWC, "R1 reset code", vcode, LOWC);
    chk(pl_rdy == 1'b0, "R1 reset ready", pl_rdy, 0);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);
    rst_n = 1'b1;
    rdy_ie = 1'b1;

    // R2 ignored code 1: nothing moves
    write_pl(2'd1);
    repeat (30) @(negedge clk);
    chk(vcode == LOWC, "R2 code 1 ignored", vcode, LOWC);
    check_flags("after ignored code");

    // R2 R3 R4 R8 climb to high with unit steps
    write_pl(2'd2);
    watch(HIC);
    check_flags("after climb");

    // R2 code 3 ignored while high: ready kept
    write_pl(2'd3);
    repeat (30) @(negedge clk);
    chk(vcode == HIC, "R2 code 3 ignored", vcode, HIC);
    check_flags("after ignored code 3");

    // R10 irq masked
    rdy_ie = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq masked", irq, 0);
    rdy_ie = 1'b1;

    // R9 write-one clear
    rdy_clr = 1'b1; @(negedge clk); rdy_clr = 1'b0; b_rdy = 0;
    @(negedge clk);
    check_flags("after clear");

    // R11 retarget mid-walk, step 8 code / period 4
    step_hgt = 2'd3; step_per = 2'd0;
    write_pl(2'd0);
    watch(LOWC);
    write_pl(2'd2);
    repeat (10) @(negedge clk);
    chk(vcode > LOWC && vcode < HIC, "R11 mid walk", vcode, LOWC + 8);
    write_pl(2'd0);
    watch(LOWC);
    check_flags("after retarget");

    // R9 set wins over a clear in the same cycle
    write_pl(2'd2);
    for (int c = 0; c < 500; c++) begin
      @(negedge clk);
      if (vcode == HIC) break;
    end
    rdy_clr = 1'b1; @(negedge clk); rdy_clr = 1'b0;
    chk(pl_rdy == 1'b1, "R9 set beats clear", pl_rdy, 1);
    rdy_clr = 1'b1; @(negedge clk); rdy_clr = 1'b0; b_rdy = 0;
    @(negedge clk);
    chk(pl_rdy == 1'b0, "R9 clear after set", pl_rdy, 0);

    // R6 standby parks low, R7 task restores high, R6 exit
    set_level(1, 0); watch(exp_tgt()); check_flags("standby entry");
    chk(vcode == LOWC, "R6 standby low", vcode, LOWC);
    set_level(1, 1); watch(exp_tgt()); check_flags("task start");
    chk(vcode == HIC, "R7 task raises level", vcode, HIC);
    set_level(1, 0); watch(exp_tgt());
    set_level(0, 0); watch(exp_tgt()); check_flags("standby exit");
    chk(vcode == HIC, "R6 exit restores level", vcode, HIC);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int a;
      a = $urandom % 6;
      case (a)
        0: write_pl(($urandom % 2) ? 2'd2 : 2'd0);
        1: write_pl(($urandom % 2) ? 2'd3 : 2'd1);
        2: set_level(~stby, task_act);
        3: set_level(stby, ~task_act);
        4: begin
             @(negedge clk); rdy_clr = 1'b1;
             @(negedge clk); rdy_clr = 1'b0; b_rdy = 0;
           end
        default: begin
             @(negedge clk);
             step_hgt = 2'($urandom % 4);
             step_per = 2'($urandom % 3);
             rdy_ie = 1'($urandom % 2);
           end
      endcase
      watch(exp_tgt());
      check_flags("random");
    end

    finish_run();
  end
endmodule